// File: doc/BRIEF.md
# CPU Reset and NMI Controller

This block belongs to the glue logic of a small CPU board. It decides when the CPU reset line and the non-maskable interrupt line are driven. Reset causes are a software-reset bit, a write to the version address, a watchdog timeout, configurable edges on two host flow-control lines and, optionally, a real-time-clock alarm line. NMI causes are the RTC alarm line, when it is steered to NMI, and a user pushbutton, when that is enabled. The pushbutton is debounced before it reaches this block.

The CPU programs a control register through a simple write port. All four external lines pass through a two-flop synchroniser and an edge stage. The reset output is stretched to a fixed minimum length and the NMI output to a short fixed pulse. Writes to the ID address restart the watchdog. Settings in the control register are cleared only by the power-on reset, so they survive the resets that this block raises itself.

Top module: `rstnmi_ctrl`

## Requirements
- R1: While `rst` is high, `cpu_rst_out` is 1, `nmi_out` is 0 and `ctrl_q` is 0. After `rst` is released, `cpu_rst_out` stays 1 for exactly RST_LEN more cycles.
- R2: A write to address 0 stores `wr_data` into the control register, which is read on `ctrl_q`. Bit 4 always reads 0. Writes to addresses 1, 2 and 3 leave `ctrl_q` unchanged.
- R3: Control bits [1:0] set the mode for `rts_a_in` and bits [3:2] set it for `rts_b_in`. The modes are: 00 ignores the line, 01 fires on a 1-to-0 change, 10 on a 0-to-1 change and 11 on any change. A firing change of the input before clock edge k drives `cpu_rst_out` high after edge k+2, and not earlier.
- R4: A write to address 0 with bit 4 set drives `cpu_rst_out` high after the write edge.
- R5: Any write to address 2 (version) drives `cpu_rst_out` high after the write edge. A write to address 1 (ID) does not raise reset.
- R6: With control bit 5 set, the watchdog raises reset 2^WDOG_W cycles after the enabling write or after the latest write to address 1. Writing address 1 more often than that prevents the reset.
- R7: A 1-to-0 change on `rtc_alarm_n` raises reset when control bit 6 is 0, and an NMI pulse with no reset when bit 6 is 1. A 0-to-1 change does nothing.
- R8: A 0-to-1 change on `user_btn` raises an NMI pulse when control bit 7 is 1. The button is ignored when bit 7 is 0, and its 1-to-0 change never has an effect.
- R9: Each reset trigger holds `cpu_rst_out` high for exactly RST_LEN cycles from the trigger edge. A new trigger while it is high restarts the count.
- R10: Each NMI pulse lasts exactly NMI_LEN cycles. `nmi_out` is never high together with `cpu_rst_out`, and a reset trigger ends a running NMI pulse at once.
- R11: The control register keeps its value through every reset this block raises. Only `rst` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 ID/watchdog service, 2 version |
| wr_data | input | 8 | Write data |
| rts_a_in | input | 1 | First host flow-control line, asynchronous |
| rts_b_in | input | 1 | Second host flow-control line, asynchronous |
| rtc_alarm_n | input | 1 | RTC reset/alarm line, active low, asynchronous |
| user_btn | input | 1 | Debounced user button, active high |
| cpu_rst_out | output | 1 | Stretched CPU reset, active high |
| nmi_out | output | 1 | NMI pulse, active high |
| ctrl_q | output | 8 | Current control register value |

## Verification
The watchdog timeout is the hardest case to reach from the ports. Its default terminal count is about a million cycles away, so the bench builds the block with a narrow counter and counts clock edges from the enabling write to the exact edge where reset rises. A second hard case is a reset that cuts off a running NMI pulse, because the trigger must land inside a window of a few cycles. The bench does this by issuing the soft-reset write on the very cycle at which it first sees the NMI high. The flow-control modes are run through every mode and direction, then through random pairs of modes and line choices.

// File: rtl/rstnmi_pkg.sv
package rstnmi_pkg;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ID   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_VER  = 2'd2;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       user_nmi_en;
    logic       rtc_to_nmi;
    logic       wdog_en;
    logic       soft_rst;
    edge_mode_e mode_b;
    edge_mode_e mode_a;
  } ctrl_t;

  function automatic logic edge_hit(edge_mode_e m, logic rise, logic fall);
    case (m)
      EDGE_FALL: edge_hit = fall;
      EDGE_RISE: edge_hit = rise;
      EDGE_ANY:  edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rstnmi_sync_edge.sv
module rstnmi_sync_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_edge
      assign rise[g] = sync_q[g] & ~prev_q[g];
      assign fall[g] = ~sync_q[g] & prev_q[g];
    end
  endgenerate

endmodule

// File: rtl/rstnmi_wdog.sv
module rstnmi_wdog #(
  parameter int CNT_W = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic service,
  input  logic hold,
  output logic fire
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = &cnt_q;
  assign fire   = en & at_max & ~service & ~hold;

  always_ff @(posedge clk) begin
    if (rst || !en || service || hold || at_max) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rstnmi_stretch.sv
module rstnmi_stretch #(
  parameter int LEN         = 64,
  parameter bit ON_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic kill,
  output logic active
);

  localparam int CNT_W = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= ON_AT_RESET;
      cnt_q  <= ON_AT_RESET ? LOAD : '0;
    end else if (kill) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end else begin
      active <= 1'b0;
    end
  end

endmodule

// File: rtl/rstnmi_ctrl.sv
module rstnmi_ctrl
  import rstnmi_pkg::*;
#(
  parameter int RST_LEN = 64,
  parameter int NMI_LEN = 4,
  parameter int WDOG_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rts_a_in,
  input  logic              rts_b_in,
  input  logic              rtc_alarm_n,
  input  logic              user_btn,
  output logic              cpu_rst_out,
  output logic              nmi_out,
  output logic [DATA_W-1:0] ctrl_q
);

  localparam int N_IN    = 4;
  localparam int IDX_RTA = 0;
  localparam int IDX_RTB = 1;
  localparam int IDX_RTC = 2;
  localparam int IDX_BTN = 3;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise;
  logic [N_IN-1:0] fall;
  logic [N_IN-1:0] evt;
  edge_mode_e      mode_sel [N_IN];

  ctrl_t ctrl_r;
  ctrl_t ctrl_nxt;
  logic  wr_ctrl, wr_id, wr_ver, soft_hit;
  logic  wdog_fire, rst_trig, nmi_trig;
  logic  rst_active, nmi_active;

  // write decode
  assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_id    = wr_en && (wr_addr == ADDR_ID);
  assign wr_ver   = wr_en && (wr_addr == ADDR_VER);
  assign soft_hit = wr_ctrl && wr_data[4];

  always_comb begin
    ctrl_nxt          = ctrl_t'(wr_data);
    ctrl_nxt.soft_rst = 1'b0;
  end

  // only power-on reset clears the settings
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r <= '0;
    end else if (wr_ctrl) begin
      ctrl_r <= ctrl_nxt;
    end
  end

  // input conditioning
  assign raw_in = {user_btn, rtc_alarm_n, rts_b_in, rts_a_in};

  rstnmi_sync_edge #(.N(N_IN)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_in),
    .rise (rise),
    .fall (fall)
  );

  always_comb begin
    mode_sel[IDX_RTA] = ctrl_r.mode_a;
    mode_sel[IDX_RTB] = ctrl_r.mode_b;
    mode_sel[IDX_RTC] = EDGE_FALL;
    mode_sel[IDX_BTN] = EDGE_RISE;
  end

  generate
    for (genvar g = 0; g < N_IN; g++) begin : g_evt
      assign evt[g] = edge_hit(mode_sel[g], rise[g], fall[g]);
    end
  endgenerate

  // watchdog
  rstnmi_wdog #(.CNT_W(WDOG_W)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl_r.wdog_en),
    .service (wr_id),
    .hold    (rst_active),
    .fire    (wdog_fire)
  );

  // cause merging: reset has priority over NMI
  assign rst_trig = soft_hit | wr_ver | wdog_fire
                  | evt[IDX_RTA] | evt[IDX_RTB]
                  | (evt[IDX_RTC] & ~ctrl_r.rtc_to_nmi);

  assign nmi_trig = ((evt[IDX_RTC] & ctrl_r.rtc_to_nmi)
                   | (evt[IDX_BTN] & ctrl_r.user_nmi_en))
                  & ~rst_trig & ~rst_active;

  rstnmi_stretch #(.LEN(RST_LEN), .ON_AT_RESET(1'b1)) u_rst_pulse (
    .clk    (clk),
    .rst    (rst),
    .start  (rst_trig),
    .kill   (1'b0),
    .active (rst_active)
  );

  rstnmi_stretch #(.LEN(NMI_LEN), .ON_AT_RESET(1'b0)) u_nmi_pulse (
    .clk    (clk),
    .rst    (rst),
    .start  (nmi_trig),
    .kill   (rst_trig | rst_active),
    .active (nmi_active)
  );

  assign cpu_rst_out = rst_active;
  assign nmi_out     = nmi_active;
  assign ctrl_q      = ctrl_r;

endmodule

// File: rtl/rstnmi_checker.sv
module rstnmi_checker
  import rstnmi_pkg::*;
#(
  parameter int RST_LEN = 64,
  parameter int NMI_LEN = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              cpu_rst_out,
  input logic              nmi_out,
  input logic [DATA_W-1:0] ctrl_q
);

  logic [15:0] rst_run;
  logic [15:0] nmi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_run <= '0;
      nmi_run <= '0;
    end else begin
      rst_run <= !cpu_rst_out ? '0 : (&rst_run ? rst_run : rst_run + 1'b1);
      nmi_run <= !nmi_out     ? '0 : (&nmi_run ? nmi_run : nmi_run + 1'b1);
    end
  end

  AST_RST_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_rst_out) |-> (rst_run >= 16'(RST_LEN))); // R9

  AST_NMI_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(nmi_out) && !cpu_rst_out) |-> (nmi_run >= 16'(NMI_LEN))); // R10

  AST_NMI_EXCL: assert property (@(posedge clk) disable iff (rst)
    cpu_rst_out |-> !nmi_out); // R10

  AST_SOFT_RST: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_CTRL && wr_data[4]) |=> cpu_rst_out); // R4

  AST_VER_RST: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_VER) |=> cpu_rst_out); // R5

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == ADDR_CTRL) |=> $stable(ctrl_q)); // R11

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_CTRL) |=> (ctrl_q == ($past(wr_data) & 8'hEF))); // R2

endmodule

bind rstnmi_ctrl rstnmi_checker #(.RST_LEN(RST_LEN), .NMI_LEN(NMI_LEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .cpu_rst_out (cpu_rst_out),
  .nmi_out     (nmi_out),
  .ctrl_q      (ctrl_q)
);

// File: tb/tb_rstnmi_ctrl.sv
module tb_rstnmi_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RST_LEN    = 64;
  localparam int NMI_LEN    = 4;
  localparam int WDOG_W     = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rts_a = 1'b0;
  logic       rts_b = 1'b0;
  logic       rtc_n = 1'b1;
  logic       btn = 1'b0;
  logic       cpu_rst_out;
  logic       nmi_out;
  logic [7:0] ctrl_q;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstnmi_ctrl #(.RST_LEN(RST_LEN), .NMI_LEN(NMI_LEN), .WDOG_W(WDOG_W)) dut (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rts_a_in    (rts_a),
    .rts_b_in    (rts_b),
    .rtc_alarm_n (rtc_n),
    .user_btn    (btn),
    .cpu_rst_out (cpu_rst_out),
    .nmi_out     (nmi_out),
    .ctrl_q      (ctrl_q)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(logic [1:0] m, logic o, logic n);
    case (m)
      2'b01:   exp_hit = o & ~n;
      2'b10:   exp_hit = ~o & n;
      2'b11:   exp_hit = o ^ n;
      default: exp_hit = 1'b0;
    endcase
  endfunction

  task automatic wait_pos(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (cpu_rst_out || nmi_out) @(negedge clk);
    wait_pos(2);
  endtask

  task automatic set_in(int which, logic v);
    case (which)
      0: rts_a = v;
      1: rts_b = v;
      2: rtc_n = v;
      default: btn = v;
    endcase
  endtask

  // change one line, confirm nothing yet after two edges, stop after the third
  task automatic apply(int which, logic v, string req);
    @(negedge clk);
    set_in(which, v);
    wait_pos(2);
    check({req, " early"}, int'(cpu_rst_out | nmi_out), 0);
    wait_pos(1);
  endtask

  function automatic int width_of_rst();
    return 0;
  endfunction

  task automatic measure(logic which_nmi, output int w);
    w = 0;
    while ((which_nmi ? nmi_out : cpu_rst_out) && w < 1000) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL timeout all requirements actual=running expected=finished");
    finish_run();
  end

  initial begin
    int w;
    logic cur;
    logic hit;
    logic [1:0] m;
    logic [7:0] d;
    int line;
    int seen;
    void'($urandom(32'd5150));

    // R1 power-on
    wait_pos(4);
    check("R1 rst during reset", int'(cpu_rst_out), 1);
    check("R1 nmi during reset", int'(nmi_out), 0);
    check("R1 ctrl during reset", int'(ctrl_q), 0);
    rst = 1'b0;
    wait_pos(RST_LEN - 1);
    check("R1 still held", int'(cpu_rst_out), 1);
    wait_pos(1);
    check("R1 released", int'(cpu_rst_out), 0);

    // R2 register writes
    wr(2'd0, 8'h0F);
    check("R2 readback", int'(ctrl_q), 8'h0F);
    wr(2'd3, 8'hAA);
    check("R2 addr3 ignored", int'(ctrl_q), 8'h0F);
    check("R2 addr3 no reset", int'(cpu_rst_out), 0);
    wr(2'd0, 8'h00);

    // R5 ID write does not reset
    wr(2'd1, 8'h00);
    wait_pos(2);
    check("R5 id no reset", int'(cpu_rst_out), 0);
    check("R2 id keeps ctrl", int'(ctrl_q), 0);

    // R3 directed: every line, mode, direction
    for (int ln = 0; ln < 2; ln++) begin
      for (int md = 0; md < 4; md++) begin
        for (int dir = 0; dir < 2; dir++) begin
          m = 2'(md);
          d = (ln == 0) ? {6'd0, m} : {4'd0, m, 2'd0};
          wr(2'd0, d);
          check("R2 mode readback", int'(ctrl_q), int'(d));
          cur = (ln == 0) ? rts_a : rts_b;
          hit = exp_hit(m, cur, ~cur);
          apply(ln, ~cur, "R3");
          check("R3 rts edge", int'(cpu_rst_out), int'(hit));
          wait_idle();
        end
      end
    end

    // R3 random modes on both lines
    for (int it = 0; it < 24; it++) begin
      d = {4'd0, 4'($urandom)};
      wr(2'd0, d);
      line = int'($urandom % 2);
      m = (line == 0) ? d[1:0] : d[3:2];
      cur = (line == 0) ? rts_a : rts_b;
      hit = exp_hit(m, cur, ~cur);
      apply(line, ~cur, "R3");
      check("R3 random rts", int'(cpu_rst_out), int'(hit));
      wait_idle();
    end
    wr(2'd0, 8'h00);

    // R4 / R9 soft reset, width and retrigger
    wr(2'd0, 8'h13);
    check("R4 soft reset", int'(cpu_rst_out), 1);
    check("R11 modes kept, bit4 clear", int'(ctrl_q), 8'h03);
    measure(1'b0, w);
    check("R9 reset width", w, RST_LEN);
    wr(2'd0, 8'h10);
    wait_pos(20);
    wr(2'd2, 8'h5A);
    check("R5 version reset", int'(cpu_rst_out), 1);
    measure(1'b0, w);
    check("R9 retrigger width", w, RST_LEN);
    wait_idle();

    // R6 watchdog timeout
    wr(2'd0, 8'h20);
    wait_pos((1 << WDOG_W) - 1);
    check("R6 before terminal", int'(cpu_rst_out), 0);
    wait_pos(1);
    check("R6 watchdog reset", int'(cpu_rst_out), 1);
    check("R11 enable kept", int'(ctrl_q), 8'h20);
    wait_idle();
    wr(2'd0, 8'h20);
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      for (int c = 0; c < 150; c++) begin
        @(negedge clk);
        if (cpu_rst_out) seen = 1;
      end
      wr(2'd1, 8'h00);
      if (cpu_rst_out) seen = 1;
    end
    check("R6 serviced no reset", seen, 0);
    wr(2'd0, 8'h00);

    // R7 RTC steering
    apply(2, 1'b0, "R7");
    check("R7 rtc reset", int'(cpu_rst_out), 1);
    check("R7 rtc no nmi", int'(nmi_out), 0);
    wait_idle();
    apply(2, 1'b1, "R7");
    check("R7 rtc rise ignored", int'(cpu_rst_out | nmi_out), 0);
    wr(2'd0, 8'h40);
    apply(2, 1'b0, "R7");
    check("R7 rtc nmi", int'(nmi_out), 1);
    check("R7 rtc nmi no reset", int'(cpu_rst_out), 0);
    measure(1'b1, w);
    check("R10 nmi width", w, NMI_LEN);
    apply(2, 1'b1, "R7");

    // R8 user button
    wr(2'd0, 8'h00);
    apply(3, 1'b1, "R8");
    check("R8 disabled ignored", int'(nmi_out), 0);
    apply(3, 1'b0, "R8");
    wr(2'd0, 8'h80);
    apply(3, 1'b1, "R8");
    check("R8 button nmi", int'(nmi_out), 1);
    measure(1'b1, w);
    check("R10 button nmi width", w, NMI_LEN);
    apply(3, 1'b0, "R8");
    check("R8 release ignored", int'(nmi_out), 0);

    // R10 reset cuts a running NMI short
    apply(3, 1'b1, "R10");
    check("R10 nmi started", int'(nmi_out), 1);
    wr(2'd0, 8'h90);
    check("R10 nmi killed", int'(nmi_out), 0);
    check("R10 reset wins", int'(cpu_rst_out), 1);
    check("R11 kept across soft reset", int'(ctrl_q), 8'h80);
    wait_idle();
    check("R10 nmi stays low", int'(nmi_out), 0);

    finish_run();
  end

endmodule